// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the mode state machine of an on-chip clock generator. It holds a small control register with a clock-source select field, a low-power bit and a bit that keeps the internal reference clock running through stop. From these settings and from the system stop request it places the clock generator in one of four states: FLL engaged, FLL bypassed, FLL bypassed low power, or Stop. The oscillator and the frequency-locked loop are outside the block. The FLL is represented only by its lock-status input.

The controller drives three things. The first is the select line of the output clock multiplexer, which chooses the FLL clock or the internal reference. The second is the FLL enable. The third is the enable of the internal reference clock output. It also reports the active mode on a two-bit status field and exposes the fixed FLL multiplication factor.

Stop remembers the mode that was active before it and returns to that mode when stop ends. Register writes that arrive while stop is requested are held and take effect only when stop ends.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: A synchronous reset puts the block in FLL-engaged mode with the select field and both other bits cleared: `mode_status` = 00, `fll_en` = 1, `out_sel_fll` = 0, `iref_out_en` = 1.
- R2: An accepted write with `wr_sel` = 0 gives FLL-engaged mode at the next clock edge: `mode_status` = 00 and `fll_en` = 1.
- R3: An accepted write with `wr_sel` = 1 and `wr_lp` = 0 gives bypassed mode at the next edge: `mode_status` = 01, `fll_en` = 1, `out_sel_fll` = 0.
- R4: An accepted write with `wr_sel` = 1 and `wr_lp` = 1 gives bypassed low-power mode at the next edge: `mode_status` = 10, `fll_en` = 0, `out_sel_fll` = 0.
- R5: `fll_mult` always reads 512.
- R6: While `stop_req` is high, the block enters Stop at the next edge from any mode: `mode_status` = 11, `fll_en` = 0, `out_sel_fll` = 0.
- R7: When `stop_req` falls, the block leaves Stop at the next edge. If no write arrived during stop, it returns to the mode that was active before stop. A reset during stop ends in FLL-engaged mode.
- R8: In Stop, `iref_out_en` equals the reference-stop-enable bit. Outside Stop, `iref_out_en` is 1.
- R9: A write with `wr_sel` = 2 or 3 is discarded entirely. The mode and all three register fields keep their values.
- R10: A write made while `stop_req` is high is held. This includes a write in the same cycle as stop entry. Such a write changes neither `mode_status` nor `iref_out_en` during that stop, and it is applied when stop ends. A later write in the same stop overrides an earlier one.
- R11: `out_sel_fll` is 1 only in FLL-engaged mode. It rises one edge after the block is in engaged mode with `fll_locked` high, and then stays high until the mode changes. It is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 2 | Clock-source select value to write (0 engaged, 1 bypassed, 2 and 3 reserved) |
| wr_lp | input | 1 | Low-power bit to write |
| wr_iref_stop | input | 1 | Reference-stop-enable bit to write |
| stop_req | input | 1 | System stop request (level) |
| fll_locked | input | 1 | FLL lock status |
| out_sel_fll | output | 1 | Output mux select: 1 FLL clock, 0 internal reference |
| fll_en | output | 1 | FLL enable |
| iref_out_en | output | 1 | Internal reference clock output enable |
| mode_status | output | 2 | Active mode: 00 engaged, 01 bypassed, 10 bypassed low power, 11 stop |
| fll_mult | output | 10 | Fixed FLL multiplication factor (512) |

## Verification
Two events can fall in the same clock cycle: a register write and an edge of the stop request. The bench raises `stop_req` in the same cycle as a write that changes both the mode and the reference-stop bit. It then checks that Stop is entered and that `iref_out_en` still follows the old bit. A second case drives a write in the cycle in which `stop_req` falls, and checks that the mode after the stop is the one that write selects. A wider sweep walks every start mode through every write value and a stop round trip, and compares the result against a mode computed from the written fields.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int SEL_W      = 2;
    localparam int MULT_W     = 10;
    localparam int FLL_MULT   = 512;
    localparam int SEL_ENGAGE = 0;
    localparam int SEL_BYPASS = 1;

    typedef enum logic [1:0] {
        MODE_ENG   = 2'b00,
        MODE_BYP   = 2'b01,
        MODE_BYPLP = 2'b10,
        MODE_STOP  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             lp;
        logic             iref_stop;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{sel: '0, lp: 1'b0, iref_stop: 1'b0};

    function automatic logic sel_legal(input logic [SEL_W-1:0] s);
        return (s == SEL_W'(SEL_ENGAGE)) || (s == SEL_W'(SEL_BYPASS));
    endfunction

    function automatic mode_e decode_mode(input ctrl_t c);
        if (c.sel == SEL_W'(SEL_ENGAGE))
            return MODE_ENG;
        else if (c.lp)
            return MODE_BYPLP;
        else
            return MODE_BYP;
    endfunction

    function automatic logic fll_running(input mode_e m);
        return (m == MODE_ENG) || (m == MODE_BYP);
    endfunction

endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
    import clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_stop,
    input  logic             stop_req,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_lp,
    input  logic             wr_iref_stop,
    output ctrl_t            active_q,
    output ctrl_t            next_cfg
);

    ctrl_t pend_q;
    logic  pend_vld_q;
    logic  wr_accept;
    ctrl_t base_cfg;

    assign wr_accept = wr_en && sel_legal(wr_sel);
    assign base_cfg  = (in_stop && pend_vld_q) ? pend_q : active_q;

    always_comb begin
        next_cfg = base_cfg;
        if (wr_accept) begin
            next_cfg.sel       = wr_sel;
            next_cfg.lp        = wr_lp;
            next_cfg.iref_stop = wr_iref_stop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= CTRL_RST;
            pend_q     <= CTRL_RST;
            pend_vld_q <= 1'b0;
        end else if (!stop_req) begin
            active_q   <= next_cfg;
            pend_vld_q <= 1'b0;
        end else begin
            pend_q     <= next_cfg;
            pend_vld_q <= pend_vld_q | wr_accept;
        end
    end

    // The active register is frozen while stop is requested (R10)
    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stop_req && in_stop) |=> $stable(active_q)); // R10

endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
    import clkmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_req,
    input  ctrl_t next_cfg,
    output mode_e state_q,
    output mode_e state_d
);

    always_comb begin
        if (rst)
            state_d = MODE_ENG;
        else if (stop_req)
            state_d = MODE_STOP;
        else
            state_d = decode_mode(next_cfg);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= MODE_ENG;
        else
            state_q <= state_d;
    end

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (state_q == MODE_STOP)); // R6

    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_STOP && !stop_req) |=> (state_q != MODE_STOP)); // R7

endmodule

// File: rtl/clkmode_outsel.sv
module clkmode_outsel
    import clkmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e state_q,
    input  mode_e state_d,
    input  logic  fll_locked,
    output logic  sel_fll_q
);

    logic hold_eng;

    assign hold_eng = (state_d == MODE_ENG);

    always_ff @(posedge clk) begin
        if (rst)
            sel_fll_q <= 1'b0;
        else if (!hold_eng)
            sel_fll_q <= 1'b0;
        else if (state_q == MODE_ENG && fll_locked)
            sel_fll_q <= 1'b1;
    end

    AST_SEL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_fll_q) |-> $past(fll_locked)); // R11

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_lp,
    input  logic              wr_iref_stop,
    input  logic              stop_req,
    input  logic              fll_locked,
    output logic              out_sel_fll,
    output logic              fll_en,
    output logic              iref_out_en,
    output logic [1:0]        mode_status,
    output logic [MULT_W-1:0] fll_mult
);

    ctrl_t active_q;
    ctrl_t next_cfg;
    mode_e state_q;
    mode_e state_d;

    clkmode_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .in_stop      (state_q == MODE_STOP),
        .stop_req     (stop_req),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_lp        (wr_lp),
        .wr_iref_stop (wr_iref_stop),
        .active_q     (active_q),
        .next_cfg     (next_cfg)
    );

    clkmode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .next_cfg (next_cfg),
        .state_q  (state_q),
        .state_d  (state_d)
    );

    clkmode_outsel u_outsel (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .state_d    (state_d),
        .fll_locked (fll_locked),
        .sel_fll_q  (out_sel_fll)
    );

    assign fll_en      = fll_running(state_q);
    assign iref_out_en = (state_q != MODE_STOP) || active_q.iref_stop;
    assign mode_status = state_q;
    assign fll_mult    = MULT_W'(FLL_MULT);

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q != MODE_STOP && !stop_req && wr_en && !sel_legal(wr_sel))
        |=> $stable(mode_status)); // R9

    AST_STOP_IREF_STEADY: assert property (@(posedge clk) disable iff (rst)
        (mode_status == MODE_STOP && $past(mode_status) == MODE_STOP && !$past(rst))
        |-> $stable(iref_out_en)); // R10

    AST_SEL_DROP_LEAVES_ENG: assert property (@(posedge clk) disable iff (rst)
        ($fell(out_sel_fll) && !$past(rst)) |-> (mode_status != MODE_ENG)); // R11

    AST_MULT_FIXED: assert property (@(posedge clk) disable iff (rst)
        fll_mult == MULT_W'(512)); // R5

endmodule

// File: tb/tb_clkgen_mode_ctrl.sv
module tb_clkgen_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic       wr_lp;
    logic       wr_iref_stop;
    logic       stop_req;
    logic       fll_locked;
    logic       out_sel_fll;
    logic       fll_en;
    logic       iref_out_en;
    logic [1:0] mode_status;
    logic [9:0] fll_mult;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    clkgen_mode_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_lp        (wr_lp),
        .wr_iref_stop (wr_iref_stop),
        .stop_req     (stop_req),
        .fll_locked   (fll_locked),
        .out_sel_fll  (out_sel_fll),
        .fll_en       (fll_en),
        .iref_out_en  (iref_out_en),
        .mode_status  (mode_status),
        .fll_mult     (fll_mult)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int s, input int l, input int i);
        wr_en = 1'b1; wr_sel = 2'(s); wr_lp = 1'(l); wr_iref_stop = 1'(i);
        step();
        wr_en = 1'b0;
    endtask

    // Outputs expected for a mode value (0..3), selection and stop bit
    task automatic chk_all(input string tag, input int m, input int sel, input int ir);
        chk({tag, " status"}, int'(mode_status), m);
        chk({tag, " fll_en"}, int'(fll_en), (m < 2) ? 1 : 0);
        chk({tag, " out_sel"}, int'(out_sel_fll), sel);
        chk({tag, " iref_en"}, int'(iref_out_en), (m == 3) ? ir : 1);
    endtask

    function automatic int mode_of(input int s, input int l);
        return (s == 0) ? 0 : ((l != 0) ? 2 : 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int m_mode;
        int m_ir;
        string t;
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_lp = 1'b0; wr_iref_stop = 1'b0;
        stop_req = 1'b0; fll_locked = 1'b0;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        chk_all("R1 reset", 0, 0, 0);
        chk("R5 multiplier", int'(fll_mult), 512);

        // Sweep: every start mode, every write value, then a stop round trip
        for (int st = 0; st < 3; st++) begin
            for (int s = 0; s < 4; s++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int i = 0; i < 2; i++) begin
                        wr((st == 0) ? 0 : 1, (st == 2) ? 1 : 0, 1 - i);
                        m_mode = st; m_ir = 1 - i;
                        chk_all("R2 R3 R4 start", m_mode, 0, m_ir);
                        wr(s, l, i);
                        if (s < 2) begin
                            m_mode = mode_of(s, l);
                            m_ir   = i;
                        end
                        t = (s >= 2) ? "R9 reserved" :
                            ((s == 0) ? "R2 engaged" : ((l != 0) ? "R4 lowpower" : "R3 bypass"));
                        chk_all(t, m_mode, 0, m_ir);
                        stop_req = 1'b1;
                        step();
                        chk_all("R6 R8 stop", 3, 0, m_ir);
                        stop_req = 1'b0;
                        step();
                        chk_all("R7 return", m_mode, 0, m_ir);
                    end
                end
            end
        end

        // Reset while stopped from bypass
        wr(1, 0, 1);
        stop_req = 1'b1;
        step();
        chk_all("R6 stop bypass", 3, 0, 1);
        rst = 1'b1; stop_req = 1'b0;
        step();
        rst = 1'b0;
        step();
        chk_all("R7 reset in stop", 0, 0, 0);

        // Writes held during stop; later write overrides earlier one
        wr(0, 0, 1);
        stop_req = 1'b1;
        step();
        wr(1, 0, 1);
        chk_all("R10 held first", 3, 0, 1);
        wr(1, 1, 0);
        chk_all("R10 held second", 3, 0, 1);
        wr(3, 0, 1);
        chk_all("R10 R9 reserved in stop", 3, 0, 1);
        stop_req = 1'b0;
        step();
        chk_all("R10 applied on exit", 2, 0, 0);
        stop_req = 1'b1;
        step();
        chk_all("R10 R8 new bit in stop", 3, 0, 0);
        stop_req = 1'b0;
        step();
        chk_all("R7 back to lowpower", 2, 0, 0);

        // Write in the same cycle as stop entry
        wr(1, 0, 0);
        stop_req = 1'b1;
        wr(0, 0, 1);
        chk_all("R10 same-cycle entry", 3, 0, 0);
        stop_req = 1'b0;
        step();
        chk_all("R10 same-cycle applied", 0, 0, 1);

        // Write in the same cycle as stop exit
        wr(1, 0, 1);
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        wr(1, 1, 0);
        chk_all("R10 exit-cycle write", 2, 0, 0);

        // Lock handling of the output select
        wr(0, 0, 0);
        step();
        chk_all("R11 no lock", 0, 0, 0);
        fll_locked = 1'b1;
        step();
        chk_all("R11 locked", 0, 1, 0);
        fll_locked = 1'b0;
        step();
        chk_all("R11 sticky", 0, 1, 0);
        fll_locked = 1'b1;
        wr(1, 0, 0);
        chk_all("R11 R3 bypass drops", 1, 0, 0);
        wr(0, 0, 0);
        chk_all("R11 first engaged cycle", 0, 0, 0);
        step();
        chk_all("R11 select after lock", 0, 1, 0);
        stop_req = 1'b1;
        step();
        chk_all("R11 R6 stop drops", 3, 0, 0);
        stop_req = 1'b0;
        step();
        chk_all("R11 R7 exit engaged", 0, 0, 0);
        step();
        chk_all("R11 reselect", 0, 1, 0);
        chk("R5 multiplier end", int'(fll_mult), 512);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule